// File: doc/BRIEF.md
# Serial EEPROM Target with Self-Timed Write Cycle

This block is a two-wire serial bus target that fronts a 256-byte register array standing in for non-volatile storage. It watches SCL and SDA on a fast system clock, recognises START and STOP, compares a 7-bit device address, and takes a one-byte word address. The host can then write data into it, either one byte or several bytes within a 16-byte page. It can also read bytes back in three ways: from the current address, from an address the host chooses (random read), or as a sequential stream.

Data bytes from the host are staged in a page buffer. They reach the array only when a self-timed internal write cycle finishes, and that cycle is launched by the STOP that closes a write. While the cycle runs, the target refuses its own address, so a host polls for completion by sending repeated address probes. A write-protect input keeps the array read-only. Under write protect the address phases are still acknowledged, but the first data byte is refused.

Top module: `seep_top`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal DEV_ADDR (default 7'h50), bit 0 being the R/W flag (1 = read). After a mismatch it leaves SDA released until the next START.
- R2: A START seen at any point restarts address decoding. A STOP seen at any point returns the target to idle.
- R3: A write transaction (address with R/W=0, word address, data byte, STOP) stores the byte at the word address. The byte is readable once the internal write cycle has ended.
- R4: Successive data bytes in one write go to successive addresses. Only the low four address bits count up, so the address wraps inside its 16-byte page.
- R5: The internal write cycle starts on the STOP that ends a write carrying at least one accepted data byte. It lasts WR_CYCLES system clocks, and the staged bytes are committed to the array at its end.
- R6: While the internal write cycle runs, the address byte is not acknowledged, whatever its R/W bit.
- R7: Once the internal write cycle has ended, the same address probe is acknowledged.
- R8: A write header (address, word address) followed by a repeated START and an address with R/W=1 returns the byte at that word address. A repeated START never launches a write cycle, and it discards data bytes staged since the last word address.
- R9: A read that begins without a word address returns the byte that follows the last one accessed. Read addresses wrap from 0xFF to 0x00.
- R10: During a read, a host ACK (SDA low in the ninth clock) makes the target send the next byte. A host NACK makes it release SDA and go idle.
- R11: With wp_i high, the address and word address are acknowledged, the first data byte is not, the array is unchanged, and no write cycle is started.
- R12: sda_oe_o is high only in the target's acknowledge clock or for a 0 data bit. Data bits are sent MSB first, and SDA is released during the host's acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level as seen on the bus |
| wp_i | input | 1 | Write protect, high makes the array read-only |
| sda_oe_o | output | 1 | Open-drain enable, high pulls SDA low |

## Verification
The hardest state to reach from the pins is the boundary of the internal write cycle. No output reports it, so it can only be seen through whether address probes are acknowledged. The bench timestamps the STOP, probes back to back until the first acknowledge, and requires that acknowledge to land no earlier than WR_CYCLES clocks after the STOP and within a few probe lengths of it. A second hard case is a repeated START arriving while data is staged but not yet committed. The bench builds this by writing a data byte and then issuing a repeated START and a random read of the same address. It expects the old value back, and an immediate acknowledge on the next probe.

// File: rtl/seep_pkg.sv
`timescale 1ns/1ps
package seep_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK
  } st_e;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_WORD,
    PH_DATA
  } ph_e;
endpackage

// File: rtl/seep_sync.sv
`timescale 1ns/1ps
module seep_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/seep_cond.sv
`timescale 1ns/1ps
module seep_cond #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic sda_o
);
  logic [1:0] raw;
  logic [1:0] syn;
  logic       scl_q, sda_q;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    seep_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw[g]),
      .q_o   (syn[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= syn[0];
      sda_q <= syn[1];
    end
  end

  assign scl_rise_o = syn[0] & ~scl_q;
  assign scl_fall_o = ~syn[0] & scl_q;
  // SDA edges count only while SCL stays high
  assign start_o    = syn[0] & scl_q & sda_q & ~syn[1];
  assign stop_o     = syn[0] & scl_q & ~sda_q & syn[1];
  assign sda_o      = syn[1];
endmodule

// File: rtl/seep_timer.sv
`timescale 1ns/1ps
module seep_timer #(
  parameter int CYCLES = 1500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (start_i)          cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/seep_array.sv
`timescale 1ns/1ps
module seep_array #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [DATA_W-1:0]        rd_data_o,
  input  logic                     clr_i,
  input  logic                     page_ld_i,
  input  logic [ADDR_W-PAGE_W-1:0] page_i,
  input  logic                     wr_i,
  input  logic [PAGE_W-1:0]        wr_idx_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic                     commit_i,
  output logic                     pend_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int HI_W  = ADDR_W - PAGE_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] stage_q [PAGE];
  logic [PAGE-1:0]   valid_q;
  logic [HI_W-1:0]   page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (commit_i) begin
      for (int i = 0; i < PAGE; i++)
        if (valid_q[i]) mem_q[{page_q, PAGE_W'(i)}] <= stage_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PAGE; i++) stage_q[i] <= '0;
      valid_q <= '0;
      page_q  <= '0;
    end else if (commit_i || clr_i) begin
      valid_q <= '0;
    end else if (page_ld_i) begin
      valid_q <= '0;
      page_q  <= page_i;
    end else if (wr_i) begin
      stage_q[wr_idx_i] <= wr_data_i;
      valid_q[wr_idx_i] <= 1'b1;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
  assign pend_o    = |valid_q;
endmodule

// File: rtl/seep_top.sv
`timescale 1ns/1ps
module seep_top
  import seep_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         ADDR_W      = 8,
  parameter int         PAGE_W      = 4,
  parameter int         WR_CYCLES   = 1500,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_oe_o
);
  localparam int HI_W = ADDR_W - PAGE_W;

  logic scl_rise, scl_fall, start_w, stop_w, sda_s;
  logic busy_w, commit_w, pend_w;
  logic [BYTE_W-1:0] rd_data;

  st_e               st_q;
  ph_e               ph_q;
  logic [3:0]        cnt_q;
  logic [BYTE_W-1:0] sh_q, tx_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rw_q, mack_q, oe_q;

  logic byte_done, ack_ok, buf_wr, page_ld, buf_clr, tmr_start;

  seep_cond #(.STAGES(SYNC_STAGES)) u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_w),
    .stop_o    (stop_w),
    .sda_o     (sda_s)
  );

  seep_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(tmr_start),
    .busy_o (busy_w),
    .done_o (commit_w)
  );

  seep_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(BYTE_W)) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_addr_i(addr_q),
    .rd_data_o(rd_data),
    .clr_i    (buf_clr),
    .page_ld_i(page_ld),
    .page_i   (sh_q[ADDR_W-1:PAGE_W]),
    .wr_i     (buf_wr),
    .wr_idx_i (addr_q[PAGE_W-1:0]),
    .wr_data_i(sh_q),
    .commit_i (commit_w),
    .pend_o   (pend_w)
  );

  assign byte_done = (st_q == ST_RX) && scl_fall && (cnt_q == 4'd8);

  always_comb begin
    unique case (ph_q)
      PH_DEV:  ack_ok = (sh_q[7:1] == DEV_ADDR) && !busy_w;
      PH_WORD: ack_ok = 1'b1;
      PH_DATA: ack_ok = !wp_i;
      default: ack_ok = 1'b0;
    endcase
  end

  assign buf_wr    = byte_done && (ph_q == PH_DATA) && !wp_i;
  assign page_ld   = byte_done && (ph_q == PH_WORD);
  assign buf_clr   = start_w && !busy_w;
  assign tmr_start = stop_w && pend_w && !busy_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_DEV;
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      addr_q <= '0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
    end else if (start_w) begin
      st_q  <= ST_RX;
      ph_q  <= PH_DEV;
      cnt_q <= '0;
    end else if (stop_w) begin
      st_q <= ST_IDLE;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise && cnt_q < 4'd8) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_s};
            cnt_q <= cnt_q + 1'b1;
          end else if (byte_done) begin
            cnt_q <= '0;
            st_q  <= ack_ok ? ST_ACK : ST_IDLE;
            unique case (ph_q)
              PH_DEV:  rw_q <= sh_q[0];
              PH_WORD: addr_q <= sh_q[ADDR_W-1:0];
              PH_DATA: if (!wp_i)
                addr_q <= {addr_q[ADDR_W-1:PAGE_W], PAGE_W'(addr_q[PAGE_W-1:0] + 1'b1)};
              default: ;
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (ph_q == PH_DEV && rw_q) begin
              st_q <= ST_TX;
              tx_q <= rd_data;
            end else begin
              st_q <= ST_RX;
              ph_q <= (ph_q == PH_DEV) ? PH_WORD : PH_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              st_q   <= ST_RACK;
              cnt_q  <= '0;
              addr_q <= addr_q + 1'b1;
            end else begin
              tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_q <= !sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              st_q <= ST_TX;
              tx_q <= rd_data;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= (st_q == ST_ACK) || (st_q == ST_TX && !tx_q[BYTE_W-1]);
  end

  assign sda_oe_o = oe_q;

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = '0;
endmodule

// File: rtl/seep_chk.sv
`timescale 1ns/1ps
module seep_chk
  import seep_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sda_oe_o,
  input logic              wp_i,
  input st_e               st_q,
  input ph_e               ph_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic              busy_w,
  input logic              stop_w,
  input logic              commit_w
);
  p_oe_source_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> ($past(st_q) == ST_ACK || $past(st_q) == ST_TX));

  p_rack_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RACK && $past(st_q) == ST_RACK) |-> !sda_oe_o);

  p_no_ack_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ACK && ph_q == PH_DEV) |-> !busy_w);

  p_wp_refuse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ACK && ph_q == PH_DATA && $past(st_q) == ST_RX) |-> !$past(wp_i));

  p_cycle_on_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_w) |-> $past(stop_w));

  p_commit_ends_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_w |=> !busy_w);

  p_page_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_DATA && $past(ph_q) == PH_DATA)
      |-> addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W]));
endmodule

bind seep_top seep_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sda_oe_o(sda_oe_o),
  .wp_i    (wp_i),
  .st_q    (st_q),
  .ph_q    (ph_q),
  .addr_q  (addr_q),
  .busy_w  (busy_w),
  .stop_w  (stop_w),
  .commit_w(commit_w)
);

// File: tb/seep_top_test.sv
`timescale 1ns/1ps
module seep_top_test;
  localparam int HALF = 20;
  localparam int WR   = 1500;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_oe;
  logic sda_line;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  seep_top #(.DEV_ADDR(DEV), .WR_CYCLES(WR)) uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .scl_i   (scl),
    .sda_i   (sda_line),
    .wp_i    (wp),
    .sda_oe_o(sda_oe)
  );

  int n_chk = 0;
  int n_fail = 0;
  longint cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hw();
    scl = 1'b1;   hw();
    sda_m = 1'b0; hw();
    scl = 1'b0;   repeat (4) @(negedge clk);
  endtask

  task automatic bus_stop(output longint t);
    sda_m = 1'b0; hw();
    scl = 1'b1;   hw();
    sda_m = 1'b1; t = cyc;
    hw();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hw();
      scl = 1'b1;   hw();
      scl = 1'b0;   repeat (4) @(negedge clk);
    end
    sda_m = 1'b1; hw();
    scl = 1'b1;   repeat (HALF / 2) @(negedge clk);
    ack = !sda_line;
    repeat (HALF / 2) @(negedge clk);
    scl = 1'b0;   repeat (4) @(negedge clk);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b, output bit oe_in_ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw();
      scl = 1'b1; repeat (HALF / 2) @(negedge clk);
      b[i] = sda_line;
      repeat (HALF / 2) @(negedge clk);
      scl = 1'b0; repeat (4) @(negedge clk);
    end
    sda_m = !mack; hw();
    scl = 1'b1; repeat (HALF / 2) @(negedge clk);
    oe_in_ack = sda_oe;
    repeat (HALF / 2) @(negedge clk);
    scl = 1'b0; repeat (4) @(negedge clk);
    sda_m = 1'b1;
  endtask

  task automatic probe(output bit ack, output longint t_ack);
    longint t;
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    t_ack = cyc;
    bus_stop(t);
  endtask

  task automatic wait_ready(output longint t_ack, output int nacks);
    bit a;
    nacks = 0;
    a = 1'b0;
    t_ack = 0;
    for (int k = 0; k < 20 && !a; k++) begin
      probe(a, t_ack);
      if (!a) nacks++;
    end
  endtask

  task automatic write_seq(input string req, input logic [7:0] a, input logic [7:0] d0,
                           input logic [7:0] d1, input logic [7:0] d2, input int n,
                           output longint t_stop);
    bit ack;
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk({req, " dev ack"}, ack, 1);
    send_byte(a, ack);           chk({req, " word ack"}, ack, 1);
    send_byte(d0, ack);          chk({req, " data0 ack"}, ack, 1);
    if (n > 1) begin send_byte(d1, ack); chk({req, " data1 ack"}, ack, 1); end
    if (n > 2) begin send_byte(d2, ack); chk({req, " data2 ack"}, ack, 1); end
    bus_stop(t_stop);
  endtask

  task automatic read_rand(input logic [7:0] a, input int n, output logic [7:0] r [3]);
    bit ack, oe;
    longint t;
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(a, ack);
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk("R8 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, r[i], oe);
      chk("R12 SDA released in host ack clock", oe, 0);
    end
    bus_stop(t);
  endtask

  task automatic t_reset();
    bit ack;
    longint t;
    chk("R12 reset oe low", sda_oe, 0);
    probe(ack, t);
    chk("R1 matching address acked after reset", ack, 1);
  endtask

  task automatic t_mismatch();
    bit ack;
    longint t;
    bus_start();
    send_byte({7'h51, 1'b0}, ack); chk("R1 foreign address not acked", ack, 0);
    send_byte(8'h00, ack);         chk("R1 ignored until next START", ack, 0);
    bus_stop(t);
  endtask

  task automatic t_byte_write();
    longint t_stop, t_ack;
    int nacks;
    bit ack;
    logic [7:0] r [3];
    write_seq("R3", 8'h10, 8'hA5, 8'h00, 8'h00, 1, t_stop);
    probe(ack, t_ack);
    chk("R6 probe refused during write cycle", ack, 0);
    wait_ready(t_ack, nacks);
    chk("R7 probe acked after write cycle", (t_ack != 0) ? 1 : 0, 1);
    chk("R5 cycle not shorter than WR_CYCLES", (t_ack - t_stop >= WR) ? 1 : 0, 1);
    chk("R7 ack soon after cycle end", (t_ack - t_stop <= WR + 1500) ? 1 : 0, 1);
    read_rand(8'h10, 1, r);
    chk("R3 byte stored", r[0], 8'hA5);
  endtask

  task automatic t_page();
    longint t_stop, t_ack;
    int nacks;
    logic [7:0] r [3];
    write_seq("R4", 8'h2E, 8'h11, 8'h22, 8'h33, 3, t_stop);
    wait_ready(t_ack, nacks);
    read_rand(8'h20, 1, r);
    chk("R4 third byte wrapped to page start", r[0], 8'h33);
    read_rand(8'h2E, 3, r);
    chk("R10 sequential byte 0", r[0], 8'h11);
    chk("R10 sequential byte 1", r[1], 8'h22);
    chk("R10 sequential crosses page on read", r[2], 8'h00);
  endtask

  task automatic t_curaddr();
    longint t_stop, t_ack, t;
    int nacks;
    bit ack, oe;
    logic [7:0] r [3];
    logic [7:0] b;
    write_seq("R9", 8'h00, 8'hC3, 8'h00, 8'h00, 1, t_stop);
    wait_ready(t_ack, nacks);
    write_seq("R9", 8'hFF, 8'h5A, 8'h00, 8'h00, 1, t_stop);
    wait_ready(t_ack, nacks);
    read_rand(8'hFF, 1, r);
    chk("R9 top byte", r[0], 8'h5A);
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk("R9 current read address ack", ack, 1);
    recv_byte(1'b0, b, oe);
    bus_stop(t);
    chk("R9 current address wraps to 0x00", b, 8'hC3);
  endtask

  task automatic t_wp();
    bit ack;
    longint t, t_ack;
    logic [7:0] r [3];
    wp = 1'b1;
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk("R11 address acked under wp", ack, 1);
    send_byte(8'h10, ack);       chk("R11 word acked under wp", ack, 1);
    send_byte(8'h99, ack);       chk("R11 first data refused", ack, 0);
    bus_stop(t);
    probe(ack, t_ack);
    chk("R11 no write cycle started", ack, 1);
    wp = 1'b0;
    read_rand(8'h10, 1, r);
    chk("R11 array unchanged", r[0], 8'hA5);
  endtask

  task automatic t_rstart();
    bit ack, oe;
    longint t, t_ack;
    logic [7:0] b;
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h40, ack);
    send_byte(8'h77, ack);       chk("R8 staged data acked", ack, 1);
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk("R2 repeated START decodes address, not busy", ack, 1);
    send_byte(8'h40, ack);
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    recv_byte(1'b0, b, oe);
    bus_stop(t);
    chk("R8 staged byte discarded by repeated START", b, 8'h00);
    probe(ack, t_ack);
    chk("R8 no write cycle after repeated START", ack, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog all-requirements actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_mismatch();
    t_byte_write();
    t_page();
    t_curaddr();
    t_wp();
    t_rstart();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule